// File: doc/BRIEF.md
# Block-Cipher Accelerator Host Interface

This block is the register front end of a 128-bit block-cipher accelerator. Software sets a mode, a chaining mode, a data type, a key size and a padding count in a control register while the block is disabled. It also writes a key bank of up to eight words and an IV bank of four words, then sets the enable bit. It then streams data through a 32-bit input data register. Four writes there make one block, and the block goes to a cipher engine. When the engine finishes, a computation-complete flag rises in the status register. Software reads the four result words in order from an output data register and clears the flag with a write-one bit in the control register.

The real cipher rounds are out of scope. A placeholder transform with a fixed latency of `LAT` cycles stands in for them, so results can be predicted. The block handles several other jobs itself. It locks the configuration while enabled and masks the trailing padding bytes of the last block to zero. It applies a per-word swap chosen by the data type on the way in and removes it on the way out. It raises a sticky error flag for out-of-order data accesses.

The bus request side is valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and it must stay stable until then. After every accepted input-data write, `req_ready` goes low for `WAIT_CYC` cycles. This holds off all requests while the key moves into the engine. Read data comes back with `rsp_valid` one cycle after the read is taken, and there is no back-pressure on the response.

Top module: `cipher_host_if`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0 and `req_ready` is 1.
- R2: The control word is at address 0, with enable at bit 0, mode at bits 2:1, chaining mode at bits 5:3, data type at bits 7:6, key size at bit 8, flag clear at bit 9 (reads 0), pad count at bits 13:10 and header phase at bit 14. While enable is 1, writes to mode, chaining, data type and key size are ignored, as are writes to the key words (addresses 8..15) and the IV words (addresses 4..7).
- R3: For each lane i (0..3), K_i is the key word seen by the engine, B_i is the prepared input word and V_i is IV word i. Mode 00 and mode 11 give (B_i ^ K_i) + V_i. Mode 10 gives (B_i - V_i) ^ K_i. Mode 01 gives K_i and ignores the data.
- R4: With key size 0, K_i = key word i. With key size 1, K_i = key word i XOR key word i+4.
- R5: The fourth accepted write to the input data register (address 2) starts a block. The complete flag (status bit 0, address 1) is set LAT+1 cycles after that write is taken.
- R6: Once the flag is set, successive reads of the output data register (address 3) return result words 0, 1, 2, 3 in order.
- R7: A control write with bit 9 set clears the complete flag. A control write with bit 9 clear leaves it unchanged.
- R8: After each accepted input-data write, `req_ready` is low for exactly WAIT_CYC cycles.
- R9: A pad count n marks the last n bytes of the block as padding and sets them to zero. Byte 0 of the block is bits 31:24 of the first word, and byte 15 is bits 7:0 of the fourth word. The count is ignored while the header-phase bit is 1.
- R10: The data-type code selects the swap within each word: 00 none, 01 half-word swap, 10 byte reversal, 11 bit reversal. The swap is applied to input words before masking and to output words on read.
- R11: While the block is enabled, two accesses are errors: an input-data write while a block is busy or the flag is set, and an output-data read while the flag is clear. Either one sets the sticky error flag (status bit 1) and is dropped, and a dropped read returns 0.
- R12: A control write with enable 0 clears the error flag, the complete flag, the word counters and any block in progress, but keeps the key and IV words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is taken |
| rsp_rdata | output | 32 | Read data |

## Verification
Read data appears one cycle after a read is taken, and the bench samples it on the falling edge after acceptance. `req_ready` goes low on the edge that takes an input-data write and stays low for WAIT_CYC cycles. The bench counts low falling edges right after the first write of each block. The complete flag is set LAT+1 edges after the fourth write, so the first status read that shows it is taken LAT+2 cycles after that write, or WAIT_CYC+1 cycles if the wait is longer. The bench polls status back to back and compares the acceptance cycle against that number.

// File: rtl/cih_pkg.sv
package cih_pkg;
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_STAT = 4'd1;
  localparam logic [3:0] A_DIN  = 4'd2;
  localparam logic [3:0] A_DOUT = 4'd3;

  typedef enum logic [1:0] {
    OP_ENC     = 2'b00,
    OP_DERIVE  = 2'b01,
    OP_DEC     = 2'b10,
    OP_ENC_ALT = 2'b11
  } op_e;

  // per-word reorder selected by the data-type code; every variant is self-inverse
  function automatic logic [31:0] lane_swap(input logic [1:0] dt, input logic [31:0] w);
    logic [31:0] r;
    case (dt)
      2'b01:   r = {w[15:0], w[31:16]};
      2'b10:   r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      2'b11:   for (int k = 0; k < 32; k++) r[k] = w[31-k];
      default: r = w;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cih_gather.sv
module cih_gather #(
  parameter int WAIT_CYC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din_wr,
  input  logic         din_ok,
  input  logic [31:0]  din_word,
  input  logic [3:0]   pad,
  input  logic         hdr,
  output logic         ready_o,
  output logic         start_o,
  output logic [127:0] blk_o
);
  localparam int WW = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

  logic [WW-1:0] wcnt;
  logic [1:0]    cnt;
  logic [31:0]   h0, h1, h2;
  logic [3:0]    pad_eff;
  logic [127:0]  raw, masked;

  assign ready_o = (wcnt == '0);
  assign pad_eff = hdr ? 4'd0 : pad;
  assign raw     = {din_word, h2, h1, h0};

  for (genvar b = 0; b < 16; b++) begin : g_byte
    localparam int LN = b / 4;
    localparam int BK = b % 4;
    assign masked[32*LN + 31 - 8*BK -: 8] =
      ((5'(b) + {1'b0, pad_eff}) >= 5'd16) ? 8'h00 : raw[32*LN + 31 - 8*BK -: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wcnt <= '0;
    else if (din_wr) wcnt <= WW'(WAIT_CYC);
    else if (wcnt != '0) wcnt <= wcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt     <= 2'd0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (din_ok) begin
        cnt <= cnt + 2'd1;
        if (cnt == 2'd3) begin
          blk_o   <= masked;
          start_o <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h0 <= '0; h1 <= '0; h2 <= '0;
    end else if (din_ok) begin
      case (cnt)
        2'd0:    h0 <= din_word;
        2'd1:    h1 <= din_word;
        2'd2:    h2 <= din_word;
        default: ;
      endcase
    end
  end

  // R8: a taken input write stalls the bus on the next cycle
  a_r8_wait_after_din: assert property (@(posedge clk) disable iff (!rst_n)
    din_wr |=> (!ready_o || WAIT_CYC == 0));
  // R9: with a non-zero count outside the header phase, the final byte is forced to zero
  a_r9_last_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && !$past(hdr) && $past(pad) != 4'd0) |-> (blk_o[103:96] == 8'h00));
endmodule

// File: rtl/cih_engine.sv
module cih_engine #(
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic [127:0] blk,
  input  logic [255:0] key,
  input  logic [127:0] iv,
  input  logic [1:0]   mode,
  input  logic         ks,
  input  logic         clr,
  output logic         done_o,
  output logic         busy_o,
  output logic [127:0] res_o
);
  import cih_pkg::*;
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CW-1:0] cnt;
  logic [127:0]  calc;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [31:0] k_w, b_w, v_w, r_w;
    assign b_w = blk[32*i +: 32];
    assign v_w = iv[32*i +: 32];
    assign k_w = key[32*i +: 32] ^ (ks ? key[32*(i+4) +: 32] : 32'h0);
    always_comb begin
      case (op_e'(mode))
        OP_DERIVE: r_w = k_w;
        OP_DEC:    r_w = (b_w - v_w) ^ k_w;
        default:   r_w = (b_w ^ k_w) + v_w;
      endcase
    end
    assign calc[32*i +: 32] = r_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt    <= '0;
      if (!rst_n) res_o <= '0;
    end else begin
      if (clr) done_o <= 1'b0;
      if (start) begin
        busy_o <= 1'b1;
        cnt    <= CW'(LAT - 1);
        res_o  <= calc;
      end else if (busy_o) begin
        if (cnt == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R5: a block is never both in flight and complete
  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));
  // R7: a clear with nothing finishing drops the flag
  a_r7_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !busy_o && !start) |=> !done_o);
endmodule

// File: rtl/cipher_host_if.sv
module cipher_host_if #(
  parameter int LAT      = 4,
  parameter int WAIT_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [3:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  import cih_pkg::*;

  logic         en_q, ks_q, hdr_q, err_q;
  logic [1:0]   mode_q, dt_q, ocnt_q;
  logic [2:0]   chain_q;
  logic [3:0]   npad_q;
  logic [255:0] key_q;
  logic [127:0] iv_q, blk, res;
  logic         acc, wr_ctrl, din_wr, din_ok, dout_rd, clr, g_start, e_done, e_busy;
  logic [31:0]  ctrl_rd;

  assign acc     = req_valid && req_ready;
  assign wr_ctrl = acc && req_write && (req_addr == A_CTRL);
  assign din_wr  = acc && req_write && (req_addr == A_DIN) && en_q;
  assign din_ok  = din_wr && !e_busy && !e_done && !g_start;
  assign dout_rd = acc && !req_write && (req_addr == A_DOUT);
  assign clr     = wr_ctrl && req_wdata[9];
  assign ctrl_rd = {17'b0, hdr_q, npad_q, 1'b0, ks_q, dt_q, chain_q, mode_q, en_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= '0; chain_q <= '0; dt_q <= '0;
      ks_q <= 1'b0; npad_q <= '0; hdr_q <= 1'b0;
      key_q <= '0; iv_q <= '0;
    end else if (acc && req_write) begin
      if (req_addr == A_CTRL) begin
        en_q   <= req_wdata[0];
        npad_q <= req_wdata[13:10];
        hdr_q  <= req_wdata[14];
        if (!en_q) begin
          mode_q  <= req_wdata[2:1];
          chain_q <= req_wdata[5:3];
          dt_q    <= req_wdata[7:6];
          ks_q    <= req_wdata[8];
        end
      end else if (!en_q && req_addr[3]) begin
        key_q[32*req_addr[2:0] +: 32] <= req_wdata;
      end else if (!en_q && req_addr[3:2] == 2'b01) begin
        iv_q[32*req_addr[1:0] +: 32] <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      ocnt_q <= '0;
    end else begin
      if (wr_ctrl && !req_wdata[0]) err_q <= 1'b0;
      else if (en_q && ((din_wr && !din_ok) || (dout_rd && !e_done))) err_q <= 1'b1;
      if (!en_q || clr) ocnt_q <= '0;
      else if (dout_rd && e_done) ocnt_q <= ocnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc && !req_write;
      rsp_rdata <= '0;
      if (acc && !req_write) begin
        case (req_addr)
          A_CTRL:  rsp_rdata <= ctrl_rd;
          A_STAT:  rsp_rdata <= {30'b0, err_q, e_done};
          A_DOUT:  rsp_rdata <= e_done ? lane_swap(dt_q, res[32*ocnt_q +: 32]) : 32'h0;
          default: rsp_rdata <= '0;
        endcase
      end
    end
  end

  cih_gather #(.WAIT_CYC(WAIT_CYC)) u_gather (
    .clk(clk), .rst_n(rst_n), .en(en_q), .din_wr(din_wr), .din_ok(din_ok),
    .din_word(lane_swap(dt_q, req_wdata)), .pad(npad_q), .hdr(hdr_q),
    .ready_o(req_ready), .start_o(g_start), .blk_o(blk)
  );

  cih_engine #(.LAT(LAT)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(en_q), .start(g_start), .blk(blk),
    .key(key_q), .iv(iv_q), .mode(mode_q), .ks(ks_q), .clr(clr),
    .done_o(e_done), .busy_o(e_busy), .res_o(res)
  );

  // R2: configuration and key bank hold while enabled
  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable({mode_q, chain_q, dt_q, ks_q}));
  a_r2_key_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> ($stable(key_q) && $stable(iv_q)));
  // R11: the error flag only falls through a disabling control write
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_ctrl && !req_wdata[0])) |=> err_q);
endmodule

// File: tb/sim_cipher_host_if.sv
module sim_cipher_host_if;
  localparam int LAT = 4;
  localparam int WAIT = 3;
  localparam int EXP_LAT = (LAT + 2 > WAIT + 1) ? LAT + 2 : WAIT + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  int cyc = 0, tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] key [8];
  logic [31:0] iv [4];
  logic [31:0] blkw [4];
  logic [1:0] c_mode, c_dt;
  logic [2:0] c_chain;
  logic c_ks, c_hdr;
  logic [3:0] c_pad;

  cipher_host_if #(.LAT(LAT), .WAIT_CYC(WAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sw(input logic [1:0] dt, input logic [31:0] w);
    logic [31:0] r;
    case (dt)
      2'b01:   r = {w[15:0], w[31:16]};
      2'b10:   r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      2'b11:   for (int k = 0; k < 32; k++) r[k] = w[31-k];
      default: r = w;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic en, input logic [1:0] m, input logic [2:0] ch,
      input logic [1:0] dt, input logic ks, input logic clr, input logic [3:0] pad, input logic hdr);
    return {17'b0, hdr, pad, clr, ks, dt, ch, m, en};
  endfunction

  function automatic logic [31:0] exp_word(input int i);
    logic [31:0] b, k, r;
    int pe;
    pe = c_hdr ? 0 : int'(c_pad);
    b = sw(c_dt, blkw[i]);
    for (int j = 0; j < 4; j++) if (4*i + j + pe >= 16) b[31-8*j -: 8] = 8'h00;
    k = key[i] ^ (c_ks ? key[i+4] : 32'h0);
    case (c_mode)
      2'b01:   r = k;
      2'b10:   r = (b - iv[i]) ^ k;
      default: r = (b ^ k) + iv[i];
    endcase
    return sw(c_dt, r);
  endfunction

  // entry and exit on a falling edge
  task automatic bus(input bit wr, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int acyc);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acyc = cyc; q = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] q; int t;
    bus(1'b1, a, d, q, t);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] q);
    int t;
    bus(1'b0, a, 32'h0, q, t);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [2:0] ch, input logic [1:0] dt,
                         input logic ks, input logic [3:0] pad, input logic hdr);
    c_mode = m; c_chain = ch; c_dt = dt; c_ks = ks; c_pad = pad; c_hdr = hdr;
    wr(4'd0, mk_ctrl(1'b0, m, ch, dt, ks, 1'b0, pad, hdr));
    wr(4'd0, mk_ctrl(1'b1, m, ch, dt, ks, 1'b0, pad, hdr));
  endtask

  task automatic run_block(input string tag, input bit extra);
    logic [31:0] q; int t0, t, n;
    bus(1'b1, 4'd2, blkw[0], q, t0);
    n = 0;
    while (!req_ready) begin n++; @(negedge clk); end
    chk("R8 wait cycles", 32'(n), 32'(WAIT));
    wr(4'd2, blkw[1]);
    wr(4'd2, blkw[2]);
    bus(1'b1, 4'd2, blkw[3], q, t0);
    t = t0;
    for (int p = 0; p < 40; p++) begin
      bus(1'b0, 4'd1, 32'h0, q, t);
      if (q[0]) break;
    end
    chk("R5 flag latency", 32'(t - t0), 32'(EXP_LAT));
    if (extra) begin
      wr(4'd2, 32'hdead_beef);
      rd(4'd1, q);
      chk("R11 extra write flags error", q, 32'h3);
    end
    for (int i = 0; i < 4; i++) begin
      rd(4'd3, q);
      chk($sformatf("%s/R6 word%0d", tag, i), q, exp_word(i));
    end
    wr(4'd0, mk_ctrl(1'b1, c_mode, c_chain, c_dt, c_ks, 1'b0, c_pad, c_hdr));
    rd(4'd1, q);
    chk("R7 zero clear keeps flag", q, extra ? 32'h3 : 32'h1);
    wr(4'd0, mk_ctrl(1'b1, c_mode, c_chain, c_dt, c_ks, 1'b1, c_pad, c_hdr));
    rd(4'd1, q);
    chk("R7 clear drops flag", q, extra ? 32'h2 : 32'h0);
  endtask

  task automatic fill();
    for (int i = 0; i < 4; i++) blkw[i] = $urandom;
  endtask

  initial begin
    logic [31:0] q;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'h1);
    rd(4'd0, q); chk("R1 control after reset", q, 32'h0);
    rd(4'd1, q); chk("R1 status after reset", q, 32'h0);

    for (int i = 0; i < 8; i++) begin key[i] = $urandom; wr(4'(8 + i), key[i]); end
    for (int i = 0; i < 4; i++) begin iv[i] = $urandom; wr(4'(4 + i), iv[i]); end
    set_cfg(2'b00, 3'd0, 2'b00, 1'b0, 4'd0, 1'b0);

    wr(4'd0, mk_ctrl(1'b1, 2'b10, 3'd5, 2'b11, 1'b1, 1'b0, 4'd0, 1'b0));
    rd(4'd0, q);
    chk("R2 locked fields", q, mk_ctrl(1'b1, 2'b00, 3'd0, 2'b00, 1'b0, 1'b0, 4'd0, 1'b0));
    wr(4'd8, ~key[0]);
    wr(4'd4, ~iv[0]);

    rd(4'd3, q); chk("R11 early read returns zero", q, 32'h0);
    rd(4'd1, q); chk("R11 early read flags error", q, 32'h2);
    wr(4'd0, mk_ctrl(1'b0, 2'b00, 3'd0, 2'b00, 1'b0, 1'b0, 4'd0, 1'b0));
    rd(4'd1, q); chk("R12 disable clears error", q, 32'h0);

    set_cfg(2'b00, 3'd0, 2'b00, 1'b0, 4'd0, 1'b0);
    wr(4'd2, 32'h1111_1111);
    wr(4'd2, 32'h2222_2222);
    set_cfg(2'b00, 3'd0, 2'b00, 1'b0, 4'd0, 1'b0);
    fill(); run_block("R12 fresh block, R2 key kept", 1'b0);

    set_cfg(2'b10, 3'd1, 2'b00, 1'b0, 4'd0, 1'b0); fill(); run_block("R3 decrypt", 1'b0);
    set_cfg(2'b01, 3'd0, 2'b00, 1'b0, 4'd0, 1'b0); fill(); run_block("R3 derive", 1'b0);
    set_cfg(2'b11, 3'd2, 2'b00, 1'b0, 4'd0, 1'b0); fill(); run_block("R3 code11", 1'b0);
    set_cfg(2'b00, 3'd0, 2'b00, 1'b1, 4'd0, 1'b0); fill(); run_block("R4 long key", 1'b0);
    set_cfg(2'b00, 3'd0, 2'b01, 1'b0, 4'd0, 1'b0); fill(); run_block("R10 half swap", 1'b0);
    set_cfg(2'b10, 3'd0, 2'b10, 1'b0, 4'd0, 1'b0); fill(); run_block("R10 byte swap", 1'b0);
    set_cfg(2'b00, 3'd0, 2'b11, 1'b1, 4'd0, 1'b0); fill(); run_block("R10 bit reverse", 1'b0);
    set_cfg(2'b00, 3'd0, 2'b00, 1'b0, 4'd5, 1'b0); fill(); run_block("R9 pad 5", 1'b0);
    set_cfg(2'b00, 3'd0, 2'b00, 1'b0, 4'd5, 1'b1); fill(); run_block("R9 pad ignored in header", 1'b0);
    set_cfg(2'b00, 3'd0, 2'b10, 1'b0, 4'd15, 1'b0); fill(); run_block("R9 pad 15", 1'b0);
    set_cfg(2'b00, 3'd0, 2'b00, 1'b0, 4'd0, 1'b0); fill(); run_block("R11 dropped extra write", 1'b1);

    for (int n = 0; n < 24; n++) begin
      set_cfg(2'($urandom), 3'($urandom), 2'($urandom), 1'($urandom), 4'($urandom), 1'($urandom));
      fill();
      run_block($sformatf("R3 random %0d", n), 1'b0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule